// File: doc/BRIEF.md
# Shift, Rotate and Bit-Scan Unit

A single-cycle datapath element for a 32-bit integer core. Each cycle it takes one data operand, a shift count read from a register, and a three-bit operation code. It returns either a shifted or rotated copy of the operand, the count of zero bits above its highest set bit, or the operand with its bit order reversed. The result path is combinational. The shifters are barrel shifters and the leading-zero count is a priority scan.

The unit holds three condition flags: negative, zero and carry. They are updated on the clock edge that ends a valid shift or rotate. The count-leading-zeros and bit-reverse operations never change the flags, and neither do reserved codes or idle cycles. This lets a leading-zero count or a reversal sit between a shift and the conditional step that tests its flags.

Top module: `shift_bitscan_unit`

## Requirements
- R1: Code 0 (logical left) shifts the operand left by amount[4:0] (0 to 31) and fills with zeros; amount[5] is ignored.
- R2: Code 1 (logical right) shifts right with zero fill by the amount, treating any amount above 32 as 32. An amount of 32 gives all zeros, and an amount of 0 returns the operand unchanged.
- R3: Code 2 (arithmetic right) shifts right and fills with copies of bit 31, with the same clamp to 32. An amount of 32 gives 32 copies of the sign bit.
- R4: Code 3 (rotate right) rotates by amount[4:0]. A rotation by 3 turns b31..b0 into b2 b1 b0 b31..b3, and a rotation by 0 returns the operand unchanged.
- R5: Code 4 returns, zero-extended, the number of zero bits above the most significant one bit. For an operand of zero it returns 32.
- R6: Code 5 returns the operand with bit i moved to bit 31-i.
- R7: On a rising clock edge with op_valid high and a shift or rotate code (0 to 3), flag_n takes result bit 31 and flag_z is set exactly when the result is zero.
- R8: On such an edge with a nonzero effective count, flag_c takes the last bit shifted out. That bit is operand[32-k] for a left shift by k, and operand[k-1] for a right shift or rotate by k. With an effective count of 0, flag_c is kept.
- R9: Codes 4 and 5, reserved codes 6 and 7, and cycles with op_valid low leave all three flags unchanged. Reserved codes give a result of zero.
- R10: While rst_n is low, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_valid | input | 1 | Operation present this cycle; gates flag updates |
| op_code | input | 3 | 0 lsl, 1 lsr, 2 asr, 3 ror, 4 clz, 5 rbit, 6-7 reserved |
| operand | input | 32 | Data operand |
| amount | input | 6 | Shift or rotate count taken from a register |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag: last bit shifted out |

## Verification
A corrupted shifter stage or scan priority shows on result in the same cycle it is driven, because the result path holds no state. A wrong flag value or a missed hold shows one edge later on the flag outputs. Because flags persist, a spurious write from a bit-scan or idle cycle stays visible until the next shift overwrites it. The bench compares the flags every cycle against a behavioural model, so such errors surface within a cycle. It also chains a reversal into a leading-zero count and checks the trailing-zero count this gives.

// File: rtl/shift_bitscan_unit.sv
module shift_bitscan_unit #(
  parameter int WIDTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [WIDTH-1:0]           operand,
  input  logic [$clog2(WIDTH):0]     amount,
  output logic [WIDTH-1:0]           result,
  output logic                       flag_n,
  output logic                       flag_z,
  output logic                       flag_c
);
  localparam int SW = $clog2(WIDTH);
  localparam int AW = SW + 1;

  logic [SW-1:0]      amt_low;
  logic [AW-1:0]      amt_sat;
  logic [WIDTH-1:0]   rev;
  logic [AW-1:0]      lead;
  logic [WIDTH:0]     left_ext, right_ext, rot_ext;
  logic [2*WIDTH-1:0] rot_wide;
  logic [WIDTH-1:0]   shl, shr, sar, rot;
  logic               is_shift, c_next, c_upd;

  assign amt_low = amount[SW-1:0];
  assign amt_sat = (amount > AW'(WIDTH)) ? AW'(WIDTH) : amount;

  assign left_ext  = {1'b0, operand} << amt_low;
  assign right_ext = {operand, 1'b0} >> amt_sat;
  assign rot_ext   = {operand, 1'b0} >> amt_low;
  assign rot_wide  = {operand, operand} >> amt_low;

  assign shl = left_ext[WIDTH-1:0];
  assign shr = operand >> amt_sat;
  assign sar = WIDTH'($signed(operand) >>> amt_sat);
  assign rot = rot_wide[WIDTH-1:0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev[i] = operand[WIDTH-1-i];
  end

  always_comb begin
    lead = AW'(WIDTH);
    for (int i = 0; i < WIDTH; i++)
      if (operand[i]) lead = AW'(WIDTH - 1 - i);
  end

  always_comb begin
    case (op_code)
      3'd0:    result = shl;
      3'd1:    result = shr;
      3'd2:    result = sar;
      3'd3:    result = rot;
      3'd4:    result = {{(WIDTH-AW){1'b0}}, lead};
      3'd5:    result = rev;
      default: result = '0;
    endcase
  end

  assign is_shift = (op_code <= 3'd3);

  always_comb begin
    case (op_code)
      3'd0:         begin c_upd = (amt_low != '0); c_next = left_ext[WIDTH]; end
      3'd1, 3'd2:   begin c_upd = (amt_sat != '0); c_next = right_ext[0];    end
      default:      begin c_upd = (amt_low != '0); c_next = rot_ext[0];      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (op_valid && is_shift) begin
      flag_n <= result[WIDTH-1];
      flag_z <= (result == '0);
      if (c_upd) flag_c <= c_next;
    end
  end
endmodule

// File: rtl/shift_bitscan_unit_chk.sv
module shift_bitscan_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic [2:0]             op_code,
  input logic [$clog2(WIDTH):0] amount,
  input logic [WIDTH-1:0]       result,
  input logic                   flag_n,
  input logic                   flag_z,
  input logic                   flag_c
);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > 3'd3) |=> $stable({flag_n, flag_z, flag_c}));

  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd3) |=> flag_n == $past(result[WIDTH-1]));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd3) |=> flag_z == ($past(result) == '0));

  // R8
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd0 || op_code == 3'd3) && amount[$clog2(WIDTH)-1:0] == '0)
      |=> $stable(flag_c));

  // R5
  lead_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4) |-> (result <= WIDTH));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 3'd5) |-> (result == '0));
endmodule

bind shift_bitscan_unit shift_bitscan_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .amount(amount), .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c));

// File: tb/shift_bitscan_unit_test.sv
module shift_bitscan_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [2:0]  op_code = 0;
  logic [31:0] operand = 0;
  logic [5:0]  amount = 0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c;

  int tests = 0, fails = 0;
  logic mn = 0, mz = 0, mc = 0;

  shift_bitscan_unit uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .amount(amount), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c));

  always #2 clk = ~clk;

  function automatic logic [31:0] model_res(input logic [2:0] op, input logic [31:0] d, input int amt);
    logic [31:0] r = 0;
    int k;
    case (op)
      0: begin k = amt % 32; for (int i = 0; i < 32; i++) r[i] = (i - k >= 0) ? d[i-k] : 1'b0; end
      1: begin k = amt > 32 ? 32 : amt; for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? d[i+k] : 1'b0; end
      2: begin k = amt > 32 ? 32 : amt; for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? d[i+k] : d[31]; end
      3: begin k = amt % 32; for (int i = 0; i < 32; i++) r[i] = d[(i + k) % 32]; end
      4: begin k = 0; while (k < 32 && !d[31-k]) k++; r = k; end
      5: for (int i = 0; i < 32; i++) r[i] = d[31-i];
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic v, input logic [2:0] op, input logic [31:0] d, input int amt, input string tag);
    logic [31:0] r;
    int k;
    @(negedge clk);
    check("R7/R8/R9 flags", {29'b0, flag_n, flag_z, flag_c}, {29'b0, mn, mz, mc});
    op_valid = v; op_code = op; operand = d; amount = amt[5:0];
    #1;
    r = model_res(op, d, amt);
    check(tag, result, r);
    if (v && op <= 3) begin
      mn = r[31]; mz = (r == 0);
      case (op)
        0: begin k = amt % 32; if (k > 0) mc = d[32-k]; end
        1, 2: begin k = amt > 32 ? 32 : amt; if (k > 0) mc = d[k-1]; end
        default: begin k = amt % 32; if (k > 0) mc = d[k-1]; end
      endcase
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] x, rv;
    int tz;
    repeat (3) @(negedge clk);
    check("R10 reset flags", {29'b0, flag_n, flag_z, flag_c}, 32'd0);
    rst_n = 1;
    do_op(1, 0, 32'h8000_0001, 31, "R1 lsl 31");
    do_op(1, 0, 32'h0000_0003, 32, "R1 lsl amount bit5 ignored");
    do_op(1, 0, 32'h1234_5678, 0, "R1 lsl 0 keeps carry");
    do_op(1, 1, 32'h8000_0000, 32, "R2 lsr 32");
    do_op(1, 1, 32'hFFFF_FFFF, 45, "R2 lsr clamp");
    do_op(1, 1, 32'hF0F0_0001, 1, "R2 lsr 1");
    do_op(1, 1, 32'hA5A5_A5A5, 0, "R2 lsr 0");
    do_op(1, 2, 32'h8000_0000, 32, "R3 asr 32 negative");
    do_op(1, 2, 32'h7FFF_FFFF, 33, "R3 asr clamp positive");
    do_op(1, 2, 32'h8765_4321, 4, "R3 asr 4");
    do_op(1, 3, 32'h0000_0005, 3, "R4 ror 3");
    do_op(1, 3, 32'hDEAD_BEEF, 0, "R4 ror 0");
    do_op(1, 4, 32'h0000_0000, 0, "R5 clz zero");
    do_op(1, 4, 32'h8000_0000, 9, "R5 clz msb");
    do_op(1, 4, 32'h0001_0000, 0, "R5 clz mid");
    do_op(1, 5, 32'h0000_0001, 0, "R6 rbit");
    do_op(1, 6, 32'hFFFF_FFFF, 3, "R9 reserved");
    do_op(0, 0, 32'h0000_0001, 1, "R9 idle");
    for (int i = 0; i < 400; i++)
      do_op($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), $urandom, $urandom_range(0, 63), "R1-R9 random");
    for (int i = 0; i < 64; i++) begin
      x = (i < 32) ? (32'h1 << i) : ($urandom & ~(32'h1 << (i % 8)));
      if (i == 63) x = 0;
      do_op(1, 5, x, 0, "R6 rbit chain");
      rv = result;
      do_op(1, 4, rv, 0, "R5 clz chain");
      tz = 0; while (tz < 32 && !x[tz]) tz++;
      check("R5 R6 trailing zeros", result, tz);
    end
    do_op(0, 0, 0, 0, "R9 final");
    @(negedge clk);
    check("R7/R8/R9 flags end", {29'b0, flag_n, flag_z, flag_c}, {29'b0, mn, mz, mc});
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule